// File: doc/BRIEF.md
# AHB Word-Array Memory Target

This block is a bus target on an AHB-style pipelined bus that holds a small memory built from flip-flops. When it is selected, it takes address and control from the address phase of each active transfer. It then completes the data phase after a fixed number of wait cycles, set by a parameter. Reads return the stored word on the read bus. Writes update only the byte lanes that the transfer size and the low address bits select.

A transfer to an address outside the array, or with a size wider than the data bus, gets no memory access. It gets a two-cycle error response instead. IDLE and BUSY cycles are answered at once with a zero-wait OKAY. The ready output stays high while reset is asserted, so the bus is never held up by a target that is still in reset. In a single-target system the bus-wide ready input is tied to this block's own ready output.

Top module: `sram_ahb_target`

## Requirements
- R1: While `hresetn` is low, `hreadyout` is 1 and `hresp` is 0. After reset every memory word reads back as zero.
- R2: A transfer is accepted only at a rising edge where `hsel`, `hready` and `htrans[1]` are all 1 (NONSEQ = 2'b10, SEQ = 2'b11). Changes on `haddr`, `hwrite` and `hsize` during that transfer's wait cycles have no effect on it.
- R3: For an accepted in-range transfer, `hreadyout` is 0 for exactly `WAIT_CYCLES` cycles. It is then 1 for one cycle with `hresp` at 0 (OKAY).
- R4: IDLE (2'b00), BUSY (2'b01), or `hsel` low gives `hreadyout` = 1 and `hresp` = 0 in the next cycle. The memory is not changed.
- R5: A write samples `hwdata` at the edge that ends the data phase, which is the cycle with `hreadyout` high. Byte lane i (bits 8i+7..8i) is written when (i >> `hsize`) equals (`haddr[1:0]` >> `hsize`). Here `hsize` 0 is a byte, 1 is a halfword and 2 is a word. All other lanes keep their value.
- R6: A read drives the whole stored word on `hrdata` in the cycle where `hreadyout` is high. In every other cycle `hrdata` is zero.
- R7: An address at or above `DEPTH*4`, or an `hsize` above 2, gives a two-cycle error. The first cycle has `hreadyout` 0 and `hresp` 1. The second has both at 1. No wait cycles come first, and the memory is not changed.
- R8: A new transfer presented during a data phase is accepted at the edge that completes that phase. A read of the word that the previous write just completed returns the new data, with the normal wait count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Clock; all inputs sampled on its rising edge |
| hresetn | input | 1 | Synchronous active-low reset |
| hsel | input | 1 | Target select from the address decoder |
| haddr | input | ADDR_W | Byte address of the transfer |
| htrans | input | 2 | Transfer type: IDLE, BUSY, NONSEQ, SEQ |
| hwrite | input | 1 | 1 = write, 0 = read |
| hsize | input | 3 | Transfer size as log2 of the byte count |
| hwdata | input | DATA_W | Write data, valid in the data phase |
| hready | input | 1 | Bus-wide ready; a high value ends the previous data phase |
| hreadyout | output | 1 | Ready from this target; low inserts a wait cycle |
| hresp | output | 1 | 0 = OKAY, 1 = ERROR |
| hrdata | output | DATA_W | Read data, valid in the final data-phase cycle |

## Verification
Because the bus is pipelined, the edge that completes one transfer's data phase is the same edge that samples the next transfer's address phase. The case that matters most is a write whose byte lanes are committed in the same cycle that a read of the same word is accepted. The bench provokes this by presenting a NONSEQ read while the write's wait cycles run. It then requires that the read data equal the freshly written word, and that both data phases show the programmed number of wait cycles. The reference memory model in the bench, updated lane by lane, is the judge for every read.

// File: rtl/sram_ahb_pkg.sv
// Shared encodings for the AHB memory target.
// Assumes an 8-bit byte lane and the standard two-bit transfer type encoding.
package sram_ahb_pkg;

    localparam int BYTE_W = 8;

    // Bus transfer type as driven by the manager.
    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;

    // Data-phase state of the target.
    typedef enum logic [1:0] {
        PH_FREE      = 2'b00,
        PH_DATA      = 2'b01,
        PH_ERR_FIRST = 2'b10,
        PH_ERR_LAST  = 2'b11
    } phase_e;

endpackage

// File: rtl/sram_ahb_capture.sv
// Address-phase capture for the memory target.
// Decides at each edge whether an active transfer is being accepted and
// whether it is legal (inside the array, size no wider than the bus).
// Legal transfers have direction, size and word/lane address registered.
// Assumes ADDR_W is wide enough to express DEPTH*BYTES.
module sram_ahb_capture
    import sram_ahb_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DEPTH  = 16,
    parameter int BYTES  = 4
) (
    input  logic                     hclk,
    input  logic                     hresetn,
    input  logic                     hsel,
    input  logic                     hready,
    input  logic [1:0]               htrans,
    input  logic                     hwrite,
    input  logic [2:0]               hsize,
    input  logic [ADDR_W-1:0]        haddr,
    output logic                     take_ok,
    output logic                     take_err,
    output logic                     q_write,
    output logic [2:0]               q_size,
    output logic [$clog2(DEPTH)-1:0] q_index,
    output logic [$clog2(BYTES)-1:0] q_lo
);
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int LANE_W = $clog2(BYTES);
    localparam int SPAN   = DEPTH * BYTES;
    localparam logic [ADDR_W:0] LIMIT    = (ADDR_W+1)'(SPAN);
    localparam logic [2:0]      MAX_SIZE = 3'(LANE_W);

    logic active;
    logic bad;

    // Classify the address phase seen at this edge.
    always_comb begin
        active   = hsel && hready &&
                   ((htrans == TR_NONSEQ) || (htrans == TR_SEQ));
        bad      = ({1'b0, haddr} >= LIMIT) || (hsize > MAX_SIZE);
        take_ok  = active && !bad;
        take_err = active && bad;
    end

    // Hold control of the accepted legal transfer for its data phase.
    always_ff @(posedge hclk) begin
        if (!hresetn) begin
            q_write <= 1'b0;
            q_size  <= '0;
            q_index <= '0;
            q_lo    <= '0;
        end else if (take_ok) begin
            q_write <= hwrite;
            q_size  <= hsize;
            q_index <= haddr[LANE_W +: IDX_W];
            q_lo    <= haddr[LANE_W-1:0];
        end
    end

endmodule

// File: rtl/sram_ahb_phase_ctrl.sv
// Data-phase sequencer for the memory target.
// Counts WAIT_CYCLES wait states for legal transfers and runs the two-cycle
// error response for illegal ones. A new transfer is taken only in a cycle
// where this target reports ready. Ready is high in reset.
module sram_ahb_phase_ctrl
    import sram_ahb_pkg::*;
#(
    parameter int WAIT_CYCLES = 2
) (
    input  logic hclk,
    input  logic hresetn,
    input  logic take_ok,
    input  logic take_err,
    output logic ready_o,
    output logic resp_o,
    output logic finish_o
);
    localparam int CNT_W = (WAIT_CYCLES > 0) ? $clog2(WAIT_CYCLES + 1) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WAIT_CYCLES);

    phase_e           state;
    logic [CNT_W-1:0] cnt;

    // Derive the bus-facing response from the current phase.
    always_comb begin
        finish_o = (state == PH_DATA) && (cnt == '0);
        ready_o  = (state == PH_FREE) || finish_o || (state == PH_ERR_LAST);
        resp_o   = (state == PH_ERR_FIRST) || (state == PH_ERR_LAST);
    end

    // Advance the phase and the wait counter.
    always_ff @(posedge hclk) begin
        if (!hresetn) begin
            state <= PH_FREE;
            cnt   <= '0;
        end else if (ready_o) begin
            if (take_err) begin
                state <= PH_ERR_FIRST;
                cnt   <= '0;
            end else if (take_ok) begin
                state <= PH_DATA;
                cnt   <= CNT_LOAD;
            end else begin
                state <= PH_FREE;
                cnt   <= '0;
            end
        end else if (state == PH_ERR_FIRST) begin
            state <= PH_ERR_LAST;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/sram_ahb_lanes.sv
// Byte-lane enable generator.
// Lane i is enabled when it lies in the naturally aligned block of
// 2**size bytes that contains the low address bits. Assumes size has already
// been checked to be no wider than the bus.
module sram_ahb_lanes #(
    parameter int BYTES = 4
) (
    input  logic [2:0]               size,
    input  logic [$clog2(BYTES)-1:0] lo,
    output logic [BYTES-1:0]         mask
);
    localparam int LANE_W = $clog2(BYTES);

    for (genvar i = 0; i < BYTES; i++) begin : g_lane
        // Compare the lane's block number with the address block number.
        always_comb begin
            mask[i] = ((LANE_W'(i) >> size) == (lo >> size));
        end
    end

endmodule

// File: rtl/sram_ahb_store.sv
// Flip-flop memory split into one bank per byte lane.
// Write enables are per lane. Read is asynchronous on the word index. All
// words clear to zero in reset.
module sram_ahb_store
    import sram_ahb_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32
) (
    input  logic                     hclk,
    input  logic                     hresetn,
    input  logic                     we,
    input  logic [DATA_W/BYTE_W-1:0] mask,
    input  logic [$clog2(DEPTH)-1:0] index,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata
);
    localparam int BYTES = DATA_W / BYTE_W;

    for (genvar l = 0; l < BYTES; l++) begin : g_bank
        logic [BYTE_W-1:0] bank [DEPTH];

        // Clear or update this lane's byte of the addressed word.
        always_ff @(posedge hclk) begin
            if (!hresetn) begin
                for (int w = 0; w < DEPTH; w++) begin
                    bank[w] <= '0;
                end
            end else if (we && mask[l]) begin
                bank[index] <= wdata[l*BYTE_W +: BYTE_W];
            end
        end

        // Present this lane's byte of the addressed word.
        always_comb begin
            rdata[l*BYTE_W +: BYTE_W] = bank[index];
        end
    end

endmodule

// File: rtl/sram_ahb_target.sv
// AHB-style memory target: DEPTH words of DATA_W bits with byte-lane
// writes, WAIT_CYCLES wait states on each legal transfer, and a two-cycle
// ERROR for addresses past the array or sizes wider than the bus.
// Assumes hready is the bus-wide ready, equal to hreadyout whenever this
// target owns the data phase.
module sram_ahb_target
    import sram_ahb_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 32,
    parameter int DEPTH       = 16,
    parameter int WAIT_CYCLES = 2
) (
    input  logic              hclk,
    input  logic              hresetn,
    input  logic              hsel,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [2:0]        hsize,
    input  logic [DATA_W-1:0] hwdata,
    input  logic              hready,
    output logic              hreadyout,
    output logic              hresp,
    output logic [DATA_W-1:0] hrdata
);
    localparam int BYTES  = DATA_W / BYTE_W;
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int LANE_W = $clog2(BYTES);

    logic              take_ok;
    logic              take_err;
    logic              q_write;
    logic [2:0]        q_size;
    logic [IDX_W-1:0]  q_index;
    logic [LANE_W-1:0] q_lo;
    logic              finish;
    logic [BYTES-1:0]  lane_mask;
    logic [DATA_W-1:0] word_rd;

    sram_ahb_capture #(
        .ADDR_W (ADDR_W),
        .DEPTH  (DEPTH),
        .BYTES  (BYTES)
    ) u_capture (
        .hclk     (hclk),
        .hresetn  (hresetn),
        .hsel     (hsel),
        .hready   (hready),
        .htrans   (htrans),
        .hwrite   (hwrite),
        .hsize    (hsize),
        .haddr    (haddr),
        .take_ok  (take_ok),
        .take_err (take_err),
        .q_write  (q_write),
        .q_size   (q_size),
        .q_index  (q_index),
        .q_lo     (q_lo)
    );

    sram_ahb_phase_ctrl #(
        .WAIT_CYCLES (WAIT_CYCLES)
    ) u_phase (
        .hclk     (hclk),
        .hresetn  (hresetn),
        .take_ok  (take_ok),
        .take_err (take_err),
        .ready_o  (hreadyout),
        .resp_o   (hresp),
        .finish_o (finish)
    );

    sram_ahb_lanes #(
        .BYTES (BYTES)
    ) u_lanes (
        .size (q_size),
        .lo   (q_lo),
        .mask (lane_mask)
    );

    sram_ahb_store #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W)
    ) u_store (
        .hclk    (hclk),
        .hresetn (hresetn),
        .we      (finish && q_write),
        .mask    (lane_mask),
        .index   (q_index),
        .wdata   (hwdata),
        .rdata   (word_rd)
    );

    // Drive read data only in the completing cycle of a read.
    always_comb begin
        hrdata = (finish && !q_write) ? word_rd : '0;
    end

endmodule

// File: rtl/sram_ahb_target_chk.sv
// Protocol checker for sram_ahb_target, bound to every instance.
// Watches only the top-level ports, and keeps a run-length counter so that
// the wait window is checked without deep $past.
module sram_ahb_target_chk #(
    parameter int DATA_W      = 32,
    parameter int WAIT_CYCLES = 2
) (
    input logic              hclk,
    input logic              hresetn,
    input logic              hsel,
    input logic [1:0]        htrans,
    input logic              hready,
    input logic              hreadyout,
    input logic              hresp,
    input logic [DATA_W-1:0] hrdata
);
    int low_run;

    // Count consecutive wait cycles that are not part of an error response.
    always_ff @(posedge hclk) begin
        if (!hresetn) begin
            low_run <= 0;
        end else if (!hreadyout && !hresp) begin
            low_run <= low_run + 1;
        end else begin
            low_run <= 0;
        end
    end

    assert_ready_in_reset_R1: assert property (@(posedge hclk)
        !hresetn |-> (hreadyout && !hresp));

    assert_idle_zero_wait_R4: assert property (@(posedge hclk) disable iff (!hresetn)
        (hsel && hready && !htrans[1]) |=> (hreadyout && !hresp));

    assert_wait_bound_R3: assert property (@(posedge hclk) disable iff (!hresetn)
        low_run <= WAIT_CYCLES);

    assert_err_second_R7: assert property (@(posedge hclk) disable iff (!hresetn)
        (hresp && !hreadyout) |=> (hresp && hreadyout));

    assert_err_first_R7: assert property (@(posedge hclk) disable iff (!hresetn)
        (hresp && hreadyout) |-> $past(hresp && !hreadyout));

    assert_rdata_quiet_R6: assert property (@(posedge hclk) disable iff (!hresetn)
        !hreadyout |-> (hrdata == '0));

endmodule

bind sram_ahb_target sram_ahb_target_chk #(
    .DATA_W      (DATA_W),
    .WAIT_CYCLES (WAIT_CYCLES)
) u_chk (
    .hclk      (hclk),
    .hresetn   (hresetn),
    .hsel      (hsel),
    .htrans    (htrans),
    .hready    (hready),
    .hreadyout (hreadyout),
    .hresp     (hresp),
    .hrdata    (hrdata)
);

// File: tb/test_sram_ahb_target.sv
`timescale 1ns/1ps
module test_sram_ahb_target;
    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;
    localparam int DEPTH  = 16;
    localparam int WAITS  = 2;

    logic              clk = 1'b0;
    logic              rstn = 1'b0;
    logic              hsel = 1'b0;
    logic [ADDR_W-1:0] haddr = '0;
    logic [1:0]        htrans = 2'b00;
    logic              hwrite = 1'b0;
    logic [2:0]        hsize = 3'd0;
    logic [DATA_W-1:0] hwdata = '0;
    logic              hready;
    logic              hreadyout;
    logic              hresp;
    logic [DATA_W-1:0] hrdata;

    logic [31:0] model [DEPTH];
    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    assign hready = hreadyout;

    always #2 clk = ~clk;

    sram_ahb_target #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .DEPTH (DEPTH), .WAIT_CYCLES (WAITS)
    ) i_sram_ahb_target (
        .hclk (clk), .hresetn (rstn), .hsel (hsel), .haddr (haddr),
        .htrans (htrans), .hwrite (hwrite), .hsize (hsize), .hwdata (hwdata),
        .hready (hready), .hreadyout (hreadyout), .hresp (hresp), .hrdata (hrdata)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: act=%0d cycles exp<150000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    // One non-pipelined transfer; returns at the negedge of its last response cycle.
    task automatic xfer(input logic wr, input int addr, input int sz, input logic [31:0] wd,
                        input bit exp_err, input logic [31:0] exp_rd, input string req);
        int n;
        @(negedge clk);
        hsel = 1'b1; htrans = 2'b10; haddr = ADDR_W'(addr); hwrite = wr; hsize = 3'(sz);
        @(posedge clk);
        @(negedge clk);
        hsel = 1'b0; htrans = 2'b00; haddr = ~ADDR_W'(addr); hwrite = ~wr; hsize = 3'd0;
        hwdata = wd;
        if (exp_err) begin
            chk(!hreadyout && hresp, req, {30'd0, hreadyout, hresp}, 32'h1);
            @(negedge clk);
            chk(hreadyout && hresp, req, {30'd0, hreadyout, hresp}, 32'h3);
        end else begin
            n = 0;
            while (!hreadyout && n < 20) begin
                chk(!hresp, req, {31'd0, hresp}, 32'd0);
                n++;
                @(negedge clk);
            end
            chk(n == WAITS, {req, " wait count"}, n, WAITS);
            chk(!hresp, req, {31'd0, hresp}, 32'd0);
            if (!wr) chk(hrdata == exp_rd, {req, " read"}, hrdata, exp_rd);
        end
    endtask

    task automatic model_write(input int addr, input int sz, input logic [31:0] wd);
        for (int i = 0; i < 4; i++) begin
            if ((i >> sz) == ((addr & 3) >> sz))
                model[(addr >> 2) & (DEPTH-1)][8*i +: 8] = wd[8*i +: 8];
        end
    endtask

    initial begin
        int n;
        logic [31:0] d;
        for (int w = 0; w < DEPTH; w++) model[w] = '0;

        // R1: ready high and OKAY while reset is held.
        repeat (3) begin
            @(negedge clk);
            chk(hreadyout && !hresp, "R1 reset ready", {30'd0, hreadyout, hresp}, 32'h2);
        end
        @(negedge clk); rstn = 1'b1;
        @(negedge clk);
        chk(hrdata == '0, "R6 idle hrdata zero", hrdata, 32'd0);

        // R1: every word reads zero after reset.
        for (int w = 0; w < DEPTH; w++) xfer(1'b0, w*4, 2, 32'h0, 1'b0, 32'h0, "R1 reset contents");

        // R4: IDLE, BUSY and deselected NONSEQ writes are zero-wait OKAY with no effect.
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            hsel = (k != 2); htrans = (k == 0) ? 2'b00 : (k == 1) ? 2'b01 : 2'b10;
            haddr = '0; hwrite = 1'b1; hsize = 3'd2;
            @(posedge clk);
            @(negedge clk);
            hsel = 1'b0; htrans = 2'b00; hwdata = 32'hDEAD_BEEF;
            chk(hreadyout && !hresp, "R4 idle/busy okay", {30'd0, hreadyout, hresp}, 32'h2);
            @(negedge clk);
            chk(hreadyout && !hresp, "R4 stays ready", {30'd0, hreadyout, hresp}, 32'h2);
        end
        xfer(1'b0, 0, 2, 32'h0, 1'b0, 32'h0, "R4 no memory change");

        // R5/R3/R2: sweep every aligned offset for each size, then read all words.
        for (int sz = 0; sz < 3; sz++) begin
            for (int a = 0; a < DEPTH*4; a += (1 << sz)) begin
                d = 32'h9E37_79B9 * (a + 1) ^ (32'(sz) << 28);
                xfer(1'b1, a, sz, d, 1'b0, 32'h0, "R5 write");
                model_write(a, sz, d);
            end
            for (int w = 0; w < DEPTH; w++) xfer(1'b0, w*4, 2, 32'h0, 1'b0, model[w], "R5 lane readback");
        end

        // R5: narrow writes leave other lanes intact; R6: narrow read returns whole word.
        xfer(1'b1, 13, 0, 32'hAAAA_AAAA, 1'b0, 32'h0, "R5 byte write");
        model_write(13, 0, 32'hAAAA_AAAA);
        xfer(1'b1, 26, 1, 32'h1234_5678, 1'b0, 32'h0, "R5 half write");
        model_write(26, 1, 32'h1234_5678);
        xfer(1'b0, 12, 0, 32'h0, 1'b0, model[3], "R6 byte read full word");
        xfer(1'b0, 26, 1, 32'h0, 1'b0, model[6], "R6 half read full word");

        // R7: out-of-range addresses and oversize transfers give a two-cycle error.
        xfer(1'b1, DEPTH*4, 2, 32'hFFFF_FFFF, 1'b1, 32'h0, "R7 first past end");
        xfer(1'b1, 1020, 0, 32'hFFFF_FFFF, 1'b1, 32'h0, "R7 top address");
        xfer(1'b0, 100, 2, 32'h0, 1'b1, 32'h0, "R7 read past end");
        xfer(1'b1, 0, 3, 32'hFFFF_FFFF, 1'b1, 32'h0, "R7 oversize");
        xfer(1'b0, 0, 2, 32'h0, 1'b0, model[0], "R7 no memory change");
        xfer(1'b0, (DEPTH-1)*4, 2, 32'h0, 1'b0, model[DEPTH-1], "R7 last word okay");

        // R8: write then pipelined read of the same word.
        @(negedge clk);
        hsel = 1'b1; htrans = 2'b10; haddr = 10'd20; hwrite = 1'b1; hsize = 3'd2;
        @(posedge clk);
        @(negedge clk);
        hwdata = 32'h0BAD_F00D; hwrite = 1'b0;
        n = 0;
        while (!hreadyout && n < 20) begin n++; @(negedge clk); end
        chk(n == WAITS, "R8 write waits", n, WAITS);
        @(posedge clk);
        @(negedge clk);
        hsel = 1'b0; htrans = 2'b00; haddr = '0;
        n = 0;
        while (!hreadyout && n < 20) begin n++; @(negedge clk); end
        chk(n == WAITS, "R8 read waits", n, WAITS);
        chk(hrdata == 32'h0BAD_F00D, "R8 read after write", hrdata, 32'h0BAD_F00D);
        model[5] = 32'h0BAD_F00D;
        @(negedge clk);
        chk(hrdata == '0 && hreadyout, "R6 hrdata cleared", hrdata, 32'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule